// File: doc/BRIEF.md
# Horizontal Minimum and Position Finder

This unit scans a wide operand made of eight unsigned 16-bit lanes and reports the smallest lane value together with the lane that holds it. Both answers are packed into fixed fields of a 128-bit result word. The word goes to a register and is presented one clock after the operand is accepted, with a single-cycle valid pulse.

The search is a balanced binary tree of pairwise compare-and-select nodes. Every node prefers its lower-numbered input when the two values are equal. As a result, the whole tree reports the lowest-numbered lane whenever several lanes share the minimum. The operand is taken through a valid/ready handshake. The ready signal is low while reset is held and high from the first clock after reset, so the unit accepts one operand per cycle.

Top module: `hmin_unit`

## Requirements
- R1: While reset is asserted and at the first sample after it, `out_valid` is 0 and `out_result` is all zeros. `in_ready` is 0 during reset and 1 from the first rising edge after reset is released.
- R2: An operand is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `out_valid` is 1 in the cycle after each accepted operand and 0 after every edge without an acceptance, so there is exactly one valid cycle per operand.
- R3: Lane k of the operand is `in_vec[16k+15:16k]`, for k from 0 to 7. Result bits 15:0 hold the smallest lane value.
- R4: Result bits 18:16 hold the number (0 to 7) of a lane whose value equals the reported minimum. Result bits 31:19 are zero, so the 16-bit index field is the lane number zero-extended.
- R5: When several lanes hold the minimum value, the reported lane number is the lowest of them.
- R6: Result bits 127:32 are zero in every valid result.
- R7: On edges without an acceptance, `out_result` keeps its previous value. Any change of `in_vec` while `in_valid` is 0 has no effect on it.
- R8: Lane values are compared as unsigned numbers, so 16'h7FFF is smaller than 16'h8000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present on `in_vec` |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_vec | input | 128 | Eight 16-bit unsigned lanes, lane k at bits 16k+15:16k |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_result | output | 128 | Minimum in bits 15:0, lane number in bits 31:16, zeros above |

## Verification
Presenting one result and accepting the next operand can happen on the same edge. The bench provokes this with back-to-back operands on consecutive cycles. It judges each cycle's result against its own reference model and expects `out_valid` to fall exactly one cycle after the stream ends. Tie-breaking and the minimum search also coincide inside one tree evaluation. Directed vectors place equal minima in lanes that meet at different tree levels (lanes 3 and 6, all lanes equal), and the reported lane number must be the lowest one.

// File: rtl/hmin_pkg.sv
package hmin_pkg;

    localparam int LANE_W_DEF = 16;
    localparam int LANES_DEF  = 8;

    // Bits needed to number n lanes (at least one).
    function automatic int lane_idx_bits(input int n);
        int b;
        b = 1;
        while ((1 << b) < n) b++;
        return b;
    endfunction

endpackage

// File: rtl/hmin_node.sv
module hmin_node #(
    parameter int VAL_W = 16,
    parameter int IDX_W = 3
) (
    input  logic [VAL_W-1:0] lo_val,
    input  logic [IDX_W-1:0] lo_idx,
    input  logic [VAL_W-1:0] hi_val,
    input  logic [IDX_W-1:0] hi_idx,
    output logic [VAL_W-1:0] win_val,
    output logic [IDX_W-1:0] win_idx
);

    logic take_hi;

    always_comb begin
        // Strictly smaller wins; equal values keep the lower-lane side.
        take_hi = (hi_val < lo_val);
        win_val = take_hi ? hi_val : lo_val;
        win_idx = take_hi ? hi_idx : lo_idx;
    end

endmodule

// File: rtl/hmin_tree.sv
module hmin_tree #(
    parameter int LANE_W = 16,
    parameter int LANES  = 8,
    parameter int IDX_W  = 3
) (
    input  logic [LANES*LANE_W-1:0] lanes_in,
    output logic [LANE_W-1:0]       min_val,
    output logic [IDX_W-1:0]        min_idx
);

    // Heap layout: node n has children 2n+1 (lower lanes) and 2n+2.
    localparam int NODES  = 2 * LANES - 1;
    localparam int FIRST_LEAF = LANES - 1;

    logic [LANE_W-1:0] heap_val [NODES];
    logic [IDX_W-1:0]  heap_idx [NODES];

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_leaf
            assign heap_val[FIRST_LEAF+g] = lanes_in[g*LANE_W +: LANE_W];
            assign heap_idx[FIRST_LEAF+g] = IDX_W'(g);
        end
        for (g = 0; g < FIRST_LEAF; g++) begin : g_node
            hmin_node #(
                .VAL_W (LANE_W),
                .IDX_W (IDX_W)
            ) u_node (
                .lo_val  (heap_val[2*g+1]),
                .lo_idx  (heap_idx[2*g+1]),
                .hi_val  (heap_val[2*g+2]),
                .hi_idx  (heap_idx[2*g+2]),
                .win_val (heap_val[g]),
                .win_idx (heap_idx[g])
            );
        end
    endgenerate

    assign min_val = heap_val[0];
    assign min_idx = heap_idx[0];

endmodule

// File: rtl/hmin_pack.sv
module hmin_pack #(
    parameter int LANE_W = 16,
    parameter int LANES  = 8,
    parameter int IDX_W  = 3
) (
    input  logic [LANE_W-1:0]       min_val,
    input  logic [IDX_W-1:0]        min_idx,
    output logic [LANES*LANE_W-1:0] packed_out
);

    localparam int VEC_W = LANES * LANE_W;

    always_comb begin
        packed_out                       = '0;
        packed_out[LANE_W-1:0]           = min_val;
        packed_out[LANE_W +: LANE_W]     = LANE_W'(min_idx);
    end

endmodule

// File: rtl/hmin_unit.sv
module hmin_unit #(
    parameter int LANE_W = hmin_pkg::LANE_W_DEF,
    parameter int LANES  = hmin_pkg::LANES_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*LANE_W-1:0] in_vec,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] out_result
);

    localparam int VEC_W = LANES * LANE_W;
    localparam int IDX_W = hmin_pkg::lane_idx_bits(LANES);

    typedef struct packed {
        logic             ready;
        logic             valid;
        logic [VEC_W-1:0] result;
    } hmin_state_t;

    hmin_state_t st_d, st_q;

    logic              accept;
    logic [LANE_W-1:0] tree_min;
    logic [IDX_W-1:0]  tree_idx;
    logic [VEC_W-1:0]  packed_res;

    hmin_tree #(
        .LANE_W (LANE_W),
        .LANES  (LANES),
        .IDX_W  (IDX_W)
    ) u_tree (
        .lanes_in (in_vec),
        .min_val  (tree_min),
        .min_idx  (tree_idx)
    );

    hmin_pack #(
        .LANE_W (LANE_W),
        .LANES  (LANES),
        .IDX_W  (IDX_W)
    ) u_pack (
        .min_val    (tree_min),
        .min_idx    (tree_idx),
        .packed_out (packed_res)
    );

    assign accept = in_valid && st_q.ready;

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b1;
        st_d.valid = accept;
        if (accept) begin
            st_d.result = packed_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready   = st_q.ready;
    assign out_valid  = st_q.valid;
    assign out_result = st_q.result;

    // Handshake timing
    AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);                                                   // R2
    AST_NO_VALID_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !out_valid);                                                 // R2
    AST_RESULT_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(out_result));                                        // R7

    // Field layout
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_result[VEC_W-1:2*LANE_W] == '0));                     // R6
    AST_IDX_FIELD_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_result[2*LANE_W-1:LANE_W+IDX_W] == '0));             // R4
    AST_IDX_POINTS_AT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (LANE_W'($past(in_vec) >> (out_result[LANE_W +: IDX_W] * LANE_W))
                    == out_result[LANE_W-1:0]));                                 // R4

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane_chk
            AST_MIN_NOT_ABOVE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
                accept |=> (out_result[LANE_W-1:0] <= $past(in_vec[k*LANE_W +: LANE_W]))); // R3
            AST_TIE_LOWEST_LANE: assert property (@(posedge clk) disable iff (!rst_n)
                accept |=> (($past(in_vec[k*LANE_W +: LANE_W]) != out_result[LANE_W-1:0])
                            || (out_result[LANE_W +: IDX_W] <= IDX_W'(k))));     // R5
        end
    endgenerate

endmodule

// File: tb/hmin_unit_bench.sv
module hmin_unit_bench;

    localparam int LANE_W = 16;
    localparam int LANES  = 8;
    localparam int VEC_W  = LANE_W * LANES;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [VEC_W-1:0] in_vec = '0;
    logic             out_valid;
    logic [VEC_W-1:0] out_result;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] rng = 32'h1357_9BDF;

    always #5 clk = ~clk;

    hmin_unit u_hmin_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_vec     (in_vec),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    // Reference: strict less-than scan from lane 0 keeps the lowest lane on ties.
    function automatic logic [VEC_W-1:0] ref_result(input logic [VEC_W-1:0] v);
        logic [LANE_W-1:0] best;
        int                pos;
        logic [VEC_W-1:0]  r;
        best = v[LANE_W-1:0];
        pos  = 0;
        for (int i = 1; i < LANES; i++) begin
            if (v[i*LANE_W +: LANE_W] < best) begin
                best = v[i*LANE_W +: LANE_W];
                pos  = i;
            end
        end
        r = '0;
        r[LANE_W-1:0]       = best;
        r[LANE_W +: LANE_W] = LANE_W'(pos);
        return r;
    endfunction

    function automatic logic [VEC_W-1:0] make_vec(input logic [LANE_W-1:0] fill,
                                                  input int a, input int b,
                                                  input logic [LANE_W-1:0] low);
        logic [VEC_W-1:0] v;
        for (int i = 0; i < LANES; i++) v[i*LANE_W +: LANE_W] = fill;
        if (a >= 0) v[a*LANE_W +: LANE_W] = low;
        if (b >= 0) v[b*LANE_W +: LANE_W] = low;
        return v;
    endfunction

    task automatic next_rand(output logic [VEC_W-1:0] v);
        for (int i = 0; i < 4; i++) begin
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >> 17);
            rng = rng ^ (rng << 5);
            v[i*32 +: 32] = rng;
        end
    endtask

    task automatic chk(input bit ok, input string tag,
                       input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one operand, check its result and the single-cycle valid pulse.
    task automatic send_one(input logic [VEC_W-1:0] v, input string tag);
        logic [VEC_W-1:0] exp;
        exp = ref_result(v);
        @(negedge clk);
        in_valid = 1'b1;
        in_vec   = v;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, {tag, " R2 valid"}, VEC_W'(out_valid), VEC_W'(1));
        chk(out_result == exp, {tag, " result"}, out_result, exp);
        @(negedge clk);
        chk(out_valid == 1'b0, {tag, " R2 single pulse"}, VEC_W'(out_valid), VEC_W'(0));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid in reset", VEC_W'(out_valid), VEC_W'(0));
        chk(out_result == '0, "R1 result in reset", out_result, '0);
        chk(in_ready == 1'b0, "R1 ready in reset", VEC_W'(in_ready), VEC_W'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready after reset", VEC_W'(in_ready), VEC_W'(1));
        chk(out_valid == 1'b0, "R1 valid after reset", VEC_W'(out_valid), VEC_W'(0));
        chk(out_result == '0, "R1 result after reset", out_result, '0);
    endtask

    task automatic t_random();
        logic [VEC_W-1:0] v;
        for (int n = 0; n < 40; n++) begin
            next_rand(v);
            send_one(v, "R3 R4 R6 random");
        end
    endtask

    task automatic t_ties();
        send_one(make_vec(16'h1234, -1, -1, 16'h0), "R5 all equal lane0");
        send_one(make_vec(16'hFFFF, -1, -1, 16'h0), "R5 all max lane0");
        send_one(make_vec(16'h4000, 3, 6, 16'h0011), "R5 tie lanes 3 and 6");
        send_one(make_vec(16'h4000, 1, 4, 16'h0000), "R5 tie lanes 1 and 4");
        send_one(make_vec(16'h4000, 7, -1, 16'h0002), "R4 lone min lane7");
        send_one(make_vec(16'h4000, 6, 7, 16'h0002), "R5 tie lanes 6 and 7");
    endtask

    task automatic t_unsigned();
        logic [VEC_W-1:0] v;
        v = make_vec(16'hFFFF, -1, -1, 16'h0);
        v[0*LANE_W +: LANE_W] = 16'h8000;
        v[1*LANE_W +: LANE_W] = 16'h7FFF;
        send_one(v, "R8 unsigned 7FFF below 8000");
        v = make_vec(16'h8001, 5, -1, 16'h8000);
        send_one(v, "R8 all above 7FFF");
    endtask

    task automatic t_back2back();
        logic [VEC_W-1:0] vs [5];
        for (int i = 0; i < 5; i++) next_rand(vs[i]);
        vs[2] = make_vec(16'h0100, 2, 5, 16'h0003);
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            in_valid = 1'b1;
            in_vec   = vs[i];
            @(negedge clk);
            chk(out_valid == 1'b1, "R2 back-to-back valid", VEC_W'(out_valid), VEC_W'(1));
            chk(out_result == ref_result(vs[i]), "R3 R5 back-to-back result",
                out_result, ref_result(vs[i]));
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 stream end", VEC_W'(out_valid), VEC_W'(0));
    endtask

    task automatic t_idle_hold();
        logic [VEC_W-1:0] v;
        logic [VEC_W-1:0] exp;
        v = make_vec(16'h0800, 4, -1, 16'h0040);
        exp = ref_result(v);
        send_one(v, "R7 setup");
        for (int i = 0; i < 3; i++) begin
            in_vec = make_vec(16'h0001, i, -1, 16'h0000);
            @(negedge clk);
            chk(out_valid == 1'b0, "R7 idle no valid", VEC_W'(out_valid), VEC_W'(0));
            chk(out_result == exp, "R7 idle result held", out_result, exp);
        end
    endtask

    initial begin
        t_reset();
        t_ties();
        t_unsigned();
        t_random();
        t_back2back();
        t_idle_hold();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule